// File: doc/BRIEF.md
# Convolutionally Encoded Storage FIFO

This block is a single-clock FIFO whose storage holds error-protection code instead of raw data, so that a bit flipped in the array by a particle strike can later be repaired by a decoder placed after the read port. Data enters one bit at a time. Each accepted bit goes through a rate-1/3 convolutional encoder with a two-bit memory, and the three-bit code symbol it produces is written into the storage array.

A writer marks the last bit of a frame. After that bit, the block feeds two zero bits through the encoder on its own. This flushes the encoder memory back to zero, so the next frame starts from a known state and a decoder can close the frame cleanly. While those two tail symbols are still waiting for space, new data writes are refused. The read side returns one stored three-bit symbol per accepted read, in write order, from a registered output. Decoding the symbols is left to a separate block.

Top module: `conv_store_fifo`

## Requirements
- R1: For a data bit b, with p1 the previous data bit and p2 the bit before that (both zero from reset), the stored symbol is {x, y, z} with x = b^p1^p2 in bit 2, y = b^p2 in bit 1 and z = b^p1 in bit 0.
- R2: The encoder memory is zero after reset and zero again after each frame's tail, so every frame's first symbol depends only on its first bit.
- R3: `full` is high exactly when DEPTH symbols are stored and `empty` exactly when none are; the storage never takes a symbol while full.
- R4: An accepted write with `wr_last` high is followed by two symbols encoding zero bits, stored as soon as space allows, and `wr_ready` stays low until both are stored.
- R5: A read with `rd_en` high while not empty drives the oldest stored symbol on `rd_sym` on the following clock cycle; symbols come out in the order they were stored.
- R6: A read request while empty has no effect: `rd_sym` keeps its value and `empty` stays high.
- R7: After reset `empty` is 1, `full` is 0, `wr_ready` is 1 and `rd_sym` is 0.
- R8: A write offered while `wr_ready` is low is dropped: no symbol is stored and the encoder memory is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Data bit offered this cycle |
| wr_bit | input | 1 | Data bit to encode and store |
| wr_last | input | 1 | Offered bit closes the current frame |
| wr_ready | output | 1 | A data bit offered now is accepted |
| rd_en | input | 1 | Read one stored symbol |
| rd_sym | output | 3 | Registered read symbol {x, y, z} |
| full | output | 1 | Storage holds DEPTH symbols |
| empty | output | 1 | Storage holds no symbol |

## Verification
The bench builds the block with DEPTH set to 4, so full and empty are reached within a few cycles and the tail symbols can be made to stall against a full array. With that depth, every six-bit frame pattern is swept through the encoder, followed by a long random mix of writes, frame ends and reads. This brings each encoder state transition, a tail stalled behind a full array, and reads issued on an empty FIFO within reach of a bit-level model.

// File: rtl/conv_fifo_pkg.sv
package conv_fifo_pkg;

    localparam int SYM_W    = 3;
    localparam int TAIL_LEN = 2;
    localparam int TAIL_W   = $clog2(TAIL_LEN + 1);

    typedef logic [SYM_W-1:0] sym_t;

    // hist[0] holds the newest past bit, hist[1] the one before it
    function automatic sym_t code_bit(input logic b, input logic [1:0] hist);
        return {b ^ hist[0] ^ hist[1], b ^ hist[1], b ^ hist[0]};
    endfunction

endpackage

// File: rtl/conv_enc_ctrl.sv
module conv_enc_ctrl
    import conv_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic       wr_bit,
    input  logic       wr_last,
    input  logic       full,
    output logic       wr_ready,
    output logic       push,
    output sym_t       push_sym,
    output logic       tail_busy,
    output logic [1:0] enc_state
);

    typedef struct packed {
        logic [1:0]        hist;
        logic [TAIL_W-1:0] tail;
    } enc_reg_t;

    enc_reg_t q, d;
    logic     in_bit;

    always_comb begin
        d        = q;
        push     = 1'b0;
        in_bit   = 1'b0;
        wr_ready = !full && (q.tail == '0);
        if (q.tail != '0) begin
            if (!full) begin
                push   = 1'b1;
                d.tail = q.tail - 1'b1;
            end
        end else if (wr_valid && !full) begin
            push   = 1'b1;
            in_bit = wr_bit;
            if (wr_last) begin
                d.tail = TAIL_W'(TAIL_LEN);
            end
        end
        push_sym = code_bit(in_bit, q.hist);
        if (push) begin
            d.hist = {q.hist[0], in_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign tail_busy = (q.tail != '0);
    assign enc_state = q.hist;

endmodule

// File: rtl/sym_store.sv
module sym_store
    import conv_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  sym_t push_sym,
    input  logic pop_req,
    output logic full,
    output logic empty,
    output sym_t rd_sym
);

    localparam int AW    = $clog2(DEPTH);
    localparam int CNT_W = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][SYM_W-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CNT_W-1:0]            cnt;
        sym_t                        rd;
    } store_reg_t;

    store_reg_t q, d;
    logic       do_push;
    logic       do_pop;

    always_comb begin
        d       = q;
        do_pop  = pop_req && (q.cnt != '0);
        do_push = push && (q.cnt != CNT_W'(DEPTH));
        if (do_pop) begin
            d.rd = q.mem[q.rp];
            d.rp = q.rp + 1'b1;
        end
        if (do_push) begin
            d.mem[q.wp] = push_sym;
            d.wp        = q.wp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign full   = (q.cnt == CNT_W'(DEPTH));
    assign empty  = (q.cnt == '0);
    assign rd_sym = q.rd;

endmodule

// File: rtl/conv_store_fifo.sv
module conv_store_fifo
    import conv_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             wr_bit,
    input  logic             wr_last,
    output logic             wr_ready,
    input  logic             rd_en,
    output logic [SYM_W-1:0] rd_sym,
    output logic             full,
    output logic             empty
);

    logic       push;
    sym_t       push_sym;
    logic       tail_busy;
    logic [1:0] enc_state;

    conv_enc_ctrl u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_bit    (wr_bit),
        .wr_last   (wr_last),
        .full      (full),
        .wr_ready  (wr_ready),
        .push      (push),
        .push_sym  (push_sym),
        .tail_busy (tail_busy),
        .enc_state (enc_state)
    );

    sym_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_sym (push_sym),
        .pop_req  (rd_en),
        .full     (full),
        .empty    (empty),
        .rd_sym   (rd_sym)
    );

endmodule

// File: rtl/conv_store_fifo_chk.sv
module conv_store_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       push,
    input logic       full,
    input logic       empty,
    input logic       wr_ready,
    input logic       tail_busy,
    input logic [1:0] enc_state,
    input logic       rd_en,
    input logic [2:0] rd_sym
);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);

    assert_flags_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    assert_tail_blocks_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tail_busy |-> !wr_ready);

    assert_frame_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tail_busy) |-> (enc_state == 2'b00));

    assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && !empty) |=> $stable(rd_sym));

endmodule

bind conv_store_fifo conv_store_fifo_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .full      (full),
    .empty     (empty),
    .wr_ready  (wr_ready),
    .tail_busy (tail_busy),
    .enc_state (enc_state),
    .rd_en     (rd_en),
    .rd_sym    (rd_sym)
);

// File: tb/tb_conv_store_fifo.sv
module tb_conv_store_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0, wr_bit = 1'b0, wr_last = 1'b0, rd_en = 1'b0;
    logic       wr_ready, full, empty;
    logic [2:0] rd_sym;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // bench model
    int   mq [0:65535];
    int   q_head = 0, q_tail = 0;
    logic p1 = 0, p2 = 0;
    int   m_tail = 0;
    logic [2:0] m_rd = 3'b000;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_store_fifo #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bit(wr_bit),
        .wr_last(wr_last), .wr_ready(wr_ready), .rd_en(rd_en),
        .rd_sym(rd_sym), .full(full), .empty(empty)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_sym(input logic b);
        int x = (b + p1 + p2) % 2;
        int y = (b + p2) % 2;
        int z = (b + p1) % 2;
        return x * 4 + y * 2 + z;
    endfunction

    // called at a negedge: check outputs, drive inputs, advance model one edge
    task automatic cycle(input logic v, input logic b, input logic l,
                         input logic r, input string tag, output logic acc);
        int sz = q_tail - q_head;
        chk({"R3 empty ", tag}, int'(empty), int'(sz == 0));
        chk({"R3 full ", tag}, int'(full), int'(sz == DEPTH));
        chk({"R4 wr_ready ", tag}, int'(wr_ready), int'(sz < DEPTH && m_tail == 0));
        chk({"R1/R5 rd_sym ", tag}, int'(rd_sym), int'(m_rd));
        acc = v && (sz < DEPTH) && (m_tail == 0);
        wr_valid = v; wr_bit = b; wr_last = l; rd_en = r;
        if (r && sz > 0) begin
            m_rd = 3'(mq[q_head]);
            q_head++;
        end
        if (sz < DEPTH) begin
            if (m_tail > 0) begin
                mq[q_tail] = model_sym(1'b0); q_tail++;
                p2 = p1; p1 = 1'b0; m_tail--;
            end else if (v) begin
                mq[q_tail] = model_sym(b); q_tail++;
                p2 = p1; p1 = b;
                if (l) m_tail = 2;
            end
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic acc;
        repeat (3) @(negedge clk);
        // R7: reset values
        chk("R7 empty", int'(empty), 1);
        chk("R7 full", int'(full), 0);
        chk("R7 wr_ready", int'(wr_ready), 1);
        chk("R7 rd_sym", int'(rd_sym), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: every six-bit frame, reading continuously
        for (int p = 0; p < 64; p++) begin
            for (int i = 0; i < 6; i++) begin
                acc = 1'b0;
                while (!acc) cycle(1'b1, 1'(p >> i), i == 5, 1'b1, "R2 sweep", acc);
            end
        end
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 1'b0, 1'b1, "R5 drain", acc);

        // R3 R8: fill, then offer writes that must be dropped
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, 1'(i & 1), 1'b0, 1'b0, "R3 fill", acc);
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'(i == 0), 1'b0, "R8 dropped", acc);
        // R5 R6: drain, then read on empty
        for (int i = 0; i < DEPTH + 4; i++) cycle(1'b0, 1'b0, 1'b0, 1'b1, "R6 empty read", acc);

        // R4: tail stalls behind a full array
        for (int i = 0; i < DEPTH; i++) cycle(1'b1, 1'b1, 1'(i == DEPTH - 1), 1'b0, "R4 fill", acc);
        for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b0, 1'b0, "R4 stall", acc);
        for (int i = 0; i < 10; i++) cycle(1'b1, 1'(i & 1), 1'b0, 1'(i % 3 != 0), "R4 release", acc);
        for (int i = 0; i < 8; i++) cycle(1'b0, 1'b0, 1'b0, 1'b1, "R5 drain", acc);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            int rv = $urandom;
            cycle(1'(rv), 1'(rv >> 1), (rv >> 2) % 5 == 0, 1'((rv >> 5) % 3 != 0), "R5 random", acc);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule